// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between an internal single-cycle request bus and an external asynchronous static RAM of 262144 words by 16 bits. A request carries a word address, write data, a read/write flag and a two-bit lane mask. The controller turns it into a timed sequence on the RAM pins:
- a pair of chip selects of opposite polarity;
- active-low byte-lane selects;
- an active-low write strobe;
- an active-low output enable.

It drives the shared data bus through a split interface: data out, data in, and one output-enable bit per byte lane.

Every access has three phases. A setup cycle presents the address and selects. An access window lasts a fixed number of wait cycles, derived from the clock period and the RAM's 85 ns access time. A hold cycle follows before the pins are released. While an access is in flight the controller reports busy and ignores new requests. It finishes each request with a one-cycle done pulse and, for reads, the captured data.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset, and whenever busy is low, the RAM is deselected: ramCs1N=1, ramCs2=0, ramLaneN=2'b11, ramWeN=1, ramOeN=1, dqOe=2'b00. Busy and done are low after reset.
- R2: During an access ramCs1N=0 and ramCs2=1, ramAddr equals the request address, and ramLaneN equals the inverted request mask. Mask bit 0 is the lower lane (data bits 7:0) and mask bit 1 is the upper lane (bits 15:8).
- R3: A write spends one setup cycle with selects valid and ramWeN high, then holds ramWeN low for exactly WAIT_CYC cycles, then spends one hold cycle with ramWeN high and the RAM still selected.
- R4: Address, lane selects and chip selects do not change while ramWeN is low, nor in the cycle on either side of the low window.
- R5: dqOe is set only for enabled lanes and only from the second cycle of ramWeN low through the hold cycle, which is WAIT_CYC cycles in total. dqOe is never set while ramOeN is low or in the cycle ramWeN falls. dqOut carries the write data.
- R6: A read keeps ramWeN high. It drives ramOeN low for WAIT_CYC cycles after one setup cycle. rdData is sampled at the end of the last such cycle; disabled lanes read as zero.
- R7: Done is a one-cycle pulse that arrives WAIT_CYC+2 clock edges after the edge that accepts a request with a nonzero mask.
- R8: Busy is high from the edge that accepts a request until done. Requests raised while busy are ignored and cause no RAM access and no done.
- R9: A request with mask 2'b00 never selects the RAM, and done follows one edge after acceptance.
- R10: WAIT_CYC equals ceil(ACCESS_NS / CLK_NS) + 1, which is 6 at the default 20 ns clock and 85 ns access time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, accepted when busy is low |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane enables (bit 0 lower, bit 1 upper) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Captured read data |
| ramAddr | output | 18 | RAM address pins |
| ramCs1N | output | 1 | Active-low chip select |
| ramCs2 | output | 1 | Active-high chip select |
| ramLaneN | output | 2 | Active-low byte-lane selects |
| ramWeN | output | 1 | Active-low write strobe |
| ramOeN | output | 1 | Active-low output enable |
| dqOut | output | 16 | Data toward the RAM |
| dqIn | input | 16 | Data from the RAM |
| dqOe | output | 2 | Per-lane drive enable for dqOut |

## Verification
Completion of one access and acceptance of the next can fall in the same cycle, because busy drops as done rises. The bench provokes this by issuing requests back to back. It judges the result by the second access's done latency and by the RAM model's setup and contention checks, which fail if the new address or selects move before the old strobe window has closed. A second case raises a request while the controller is busy. It is judged by the absence of an extra done and by reading back the untouched target word.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_HOLD,
    ST_SKIP
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch request fields
    logic selOn;    // chip and lane selects active
    logic weOn;     // write strobe low
    logic oeOn;     // output enable low
    logic driveOn;  // data bus driven
    logic capture;  // sample read data
  } ctlStrobe_t;

  function automatic int waitCycles(input int clkNs, input int accNs);
    return (accNs + clkNs - 1) / clkNs + 1;
  endfunction

endpackage

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int WAIT_CYC = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       reqMaskAny,
  output logic       busy,
  output logic       done,
  output ctlStrobe_t strobes
);

  localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WAIT_CYC - 1);

  ctlState_e state, stateNxt;
  logic [CNT_W-1:0] cnt;
  logic isWrite;
  logic accept;

  assign accept = reqValid && (state == ST_IDLE);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:   if (accept) stateNxt = reqMaskAny ? ST_SETUP : ST_SKIP;
      ST_SETUP:  stateNxt = ST_ACCESS;
      ST_ACCESS: if (cnt == LAST_CNT) stateNxt = ST_HOLD;
      ST_HOLD:   stateNxt = ST_IDLE;
      ST_SKIP:   stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
      done    <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= (state == ST_HOLD) || (state == ST_SKIP);
      if (accept) isWrite <= reqWrite;
      if (state == ST_ACCESS) cnt <= cnt + 1'b1;
      else                    cnt <= '0;
    end
  end

  always_comb begin
    strobes.load    = accept;
    strobes.selOn   = (state == ST_SETUP) || (state == ST_ACCESS) || (state == ST_HOLD);
    strobes.weOn    = isWrite && (state == ST_ACCESS);
    strobes.oeOn    = !isWrite && (state == ST_ACCESS);
    strobes.driveOn = isWrite && (((state == ST_ACCESS) && (cnt != '0)) || (state == ST_HOLD));
    strobes.capture = !isWrite && (state == ST_ACCESS) && (cnt == LAST_CNT);
  end

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: done only ever ends a busy period
  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

endmodule

// File: rtl/sram_lane_datapath.sv
module sram_lane_datapath
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobes,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqMask,
  input  logic [DATA_W-1:0]   dqIn,
  output logic [ADDR_W-1:0]   ramAddr,
  output logic                ramCs1N,
  output logic                ramCs2,
  output logic [DATA_W/8-1:0] ramLaneN,
  output logic                ramWeN,
  output logic                ramOeN,
  output logic [DATA_W-1:0]   dqOut,
  output logic [DATA_W/8-1:0] dqOe,
  output logic [DATA_W-1:0]   rdData
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
    end else if (strobes.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      maskQ  <= reqMask;
    end
  end

  assign ramAddr = addrQ;
  assign ramCs1N = !strobes.selOn;
  assign ramCs2  = strobes.selOn;
  assign ramWeN  = !strobes.weOn;
  assign ramOeN  = !strobes.oeOn;
  assign dqOut   = wdataQ;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign ramLaneN[l] = !(strobes.selOn && maskQ[l]);
    assign dqOe[l]     = strobes.driveOn && maskQ[l];

    always_ff @(posedge clk) begin
      if (!rstN)
        rdData[l*8 +: 8] <= '0;
      else if (strobes.capture)
        rdData[l*8 +: 8] <= maskQ[l] ? dqIn[l*8 +: 8] : 8'h00;
    end
  end

  // R5: never drive while the RAM output enable is active
  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ramOeN |-> (dqOe == '0));

  // R5: bus released in the cycle the strobe falls
  p_drive_late_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ramWeN) |-> (dqOe == '0));

  // R6: a read never pulses the write strobe
  p_read_we_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ramOeN |-> ramWeN);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 20,
  parameter int ACCESS_NS = 85
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqMask,
  output logic                busy,
  output logic                done,
  output logic [DATA_W-1:0]   rdData,
  output logic [ADDR_W-1:0]   ramAddr,
  output logic                ramCs1N,
  output logic                ramCs2,
  output logic [DATA_W/8-1:0] ramLaneN,
  output logic                ramWeN,
  output logic                ramOeN,
  output logic [DATA_W-1:0]   dqOut,
  input  logic [DATA_W-1:0]   dqIn,
  output logic [DATA_W/8-1:0] dqOe
);

  localparam int WAIT_CYC = waitCycles(CLK_NS, ACCESS_NS);

  ctlStrobe_t strobes;

  sram_lane_fsm #(.WAIT_CYC(WAIT_CYC)) u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqMaskAny(|reqMask),
    .busy      (busy),
    .done      (done),
    .strobes   (strobes)
  );

  sram_lane_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .dqIn    (dqIn),
    .ramAddr (ramAddr),
    .ramCs1N (ramCs1N),
    .ramCs2  (ramCs2),
    .ramLaneN(ramLaneN),
    .ramWeN  (ramWeN),
    .ramOeN  (ramOeN),
    .dqOut   (dqOut),
    .dqOe    (dqOe),
    .rdData  (rdData)
  );

  // R1: pins parked while idle
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (ramCs1N && !ramCs2 && ramWeN && ramOeN && (dqOe == '0) && (&ramLaneN)));

  // R2: strobe only with the chip and a lane selected
  p_we_selected_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ramWeN |-> (!ramCs1N && ramCs2 && !(&ramLaneN)));

  // R4: address and selects frozen across the strobe window
  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ramWeN |-> ($stable(ramAddr) && $stable(ramLaneN) && $stable(ramCs1N)));

  // R4: hold cycle after the strobe rises
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramWeN) |-> ($stable(ramAddr) && $stable(ramLaneN) && !ramCs1N));

  // R8: address frozen throughout a busy period
  p_busy_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(ramAddr));

endmodule

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;

  localparam int WAIT = (85 + 20 - 1) / 20 + 1;  // R10: 6 at 20 ns / 85 ns

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic busy, done;
  logic [15:0] rdData;
  logic [17:0] ramAddr;
  logic ramCs1N, ramCs2, ramWeN, ramOeN;
  logic [1:0] ramLaneN, dqOe;
  logic [15:0] dqOut, dqIn;

  always #10 clk = ~clk;

  sram_lane_ctrl u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .busy(busy), .done(done), .rdData(rdData), .ramAddr(ramAddr),
    .ramCs1N(ramCs1N), .ramCs2(ramCs2), .ramLaneN(ramLaneN),
    .ramWeN(ramWeN), .ramOeN(ramOeN), .dqOut(dqOut), .dqIn(dqIn), .dqOe(dqOe)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] initVal(input logic [7:0] a);
    return {a, ~a};
  endfunction

  // behavioural RAM (indexed by low address byte) and bench shadow
  logic [15:0] ramMem [256];
  logic [15:0] shadow [256];
  initial for (int i = 0; i < 256; i++) begin
    ramMem[i] = initVal(8'(i));
    shadow[i] = initVal(8'(i));
  end

  logic ramSel;
  assign ramSel = !ramCs1N && ramCs2;

  always_comb begin
    for (int l = 0; l < 2; l++)
      dqIn[l*8 +: 8] = (ramSel && ramWeN && !ramOeN && !ramLaneN[l]) ?
                       ramMem[ramAddr[7:0]][l*8 +: 8] : 8'hA5;
  end

  typedef struct {
    bit          isRead;
    logic [17:0] addr;
    logic [15:0] data;
    logic [1:0]  mask;
    int          doneCyc;
  } item_t;
  item_t q[$];

  // scoreboard monitor
  logic prevWeN = 1'b1, prevOeN = 1'b1, prevSel = 1'b0;
  logic [17:0] prevAddr = '0;
  logic [1:0] prevLaneN = 2'b11;
  int weRun = 0, oeRun = 0, driveRun = 0, selRun = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (ramSel && !prevSel && q.size() > 0) begin
        check(ramLaneN == ~q[0].mask, "R2 lane selects", 32'(ramLaneN), 32'(~q[0].mask));
        check(ramAddr == q[0].addr, "R2 address", 32'(ramAddr), 32'(q[0].addr));
      end
      if (!ramWeN && prevWeN) begin
        check(prevSel && prevAddr == ramAddr, "R3 setup before strobe", 32'(prevAddr), 32'(ramAddr));
        check(dqOe == 2'b00, "R5 no drive as strobe falls", 32'(dqOe), 0);
      end
      if (!ramWeN) begin
        weRun++;
        if (!prevWeN)
          check(ramSel && ramAddr == prevAddr && ramLaneN == prevLaneN, "R4 stable in strobe",
                32'(ramAddr), 32'(prevAddr));
      end
      if (ramWeN && !prevWeN) begin
        check(weRun == WAIT, "R3 strobe width", 32'(weRun), 32'(WAIT));
        check(ramSel && ramAddr == prevAddr && ramLaneN == prevLaneN, "R4 hold after strobe",
              32'(ramAddr), 32'(prevAddr));
        weRun = 0;
      end
      if (!ramOeN) oeRun++;
      if (ramOeN && !prevOeN) begin
        check(oeRun == WAIT, "R6 output enable width", 32'(oeRun), 32'(WAIT));
        oeRun = 0;
      end
      for (int l = 0; l < 2; l++) begin
        if (ramSel && ramWeN && !ramOeN && !ramLaneN[l])
          check(!dqOe[l], "R5 bus contention", 32'(dqOe), 0);
        if (ramSel && !ramWeN && !ramLaneN[l] && dqOe[l])
          ramMem[ramAddr[7:0]][l*8 +: 8] = dqOut[l*8 +: 8];
      end
      if (dqOe != 2'b00) begin
        driveRun++;
        check((dqOe & ramLaneN) == 2'b00, "R5 drive on enabled lanes", 32'(dqOe), 32'(~ramLaneN));
      end
      if (ramSel) selRun++;
      if (done) begin
        if (q.size() == 0) check(1'b0, "R8 unexpected done", 1, 0);
        else begin
          item_t it;
          it = q.pop_front();
          check(cyc == it.doneCyc, "R7 done latency", 32'(cyc), 32'(it.doneCyc));
          if (it.mask == 2'b00) check(selRun == 0, "R9 no select for empty mask", 32'(selRun), 0);
          else if (!it.isRead) check(driveRun == WAIT, "R5 drive window", 32'(driveRun), 32'(WAIT));
          if (it.isRead) check(rdData == it.data, "R6 read data", 32'(rdData), 32'(it.data));
        end
        selRun = 0;
        driveRun = 0;
      end
      prevWeN = ramWeN; prevOeN = ramOeN; prevSel = ramSel;
      prevAddr = ramAddr; prevLaneN = ramLaneN;
    end
  end

  // driver: waits for idle, issues one request, records the expectation
  task automatic doReq(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    item_t it;
    logic [15:0] expd;
    while (busy) begin @(posedge clk); #2; end
    expd = 16'h0000;
    for (int l = 0; l < 2; l++) begin
      if (m[l]) begin
        if (wr) shadow[a[7:0]][l*8 +: 8] = d[l*8 +: 8];
        else    expd[l*8 +: 8] = shadow[a[7:0]][l*8 +: 8];
      end
    end
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    it.isRead = !wr && (m != 2'b00);
    it.addr = a; it.data = expd; it.mask = m; it.doneCyc = 0;
    q.push_back(it);
    @(posedge clk); #2;
    q[q.size()-1].doneCyc = (m == 2'b00) ? cyc + 1 : cyc + WAIT + 2;
    reqValid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(posedge clk); #2;
  endtask

  initial begin : watchdog
    #(20 * 100000);
    check(1'b0, "R7 watchdog expired", 32'(cyc), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rstN = 1'b1;
    @(negedge clk);
    // R1: parked state after reset
    check(ramCs1N && !ramCs2 && ramLaneN == 2'b11, "R1 deselected", {ramCs1N, ramCs2, ramLaneN}, 4'b1011);
    check(ramWeN && ramOeN && dqOe == 2'b00, "R1 strobes idle", {ramWeN, ramOeN, dqOe}, 4'b1100);
    check(!busy && !done, "R1 busy and done low", {busy, done}, 0);
    @(posedge clk); #2;

    doReq(1'b1, 18'h00005, 16'h1234, 2'b11);            // R3 full write
    doReq(1'b0, 18'h00005, 16'h0000, 2'b11);            // R6 read back, back to back
    doReq(1'b1, 18'h00005, 16'hAB99, 2'b10);            // R2 upper lane only
    doReq(1'b0, 18'h00005, 16'h0000, 2'b01);            // R6 lower lane, upper zero
    doReq(1'b0, 18'h00005, 16'h0000, 2'b10);
    doReq(1'b1, 18'h3FFFF, 16'h55FF, 2'b01);            // top address, lower lane
    doReq(1'b0, 18'h3FFFF, 16'h0000, 2'b11);
    doReq(1'b1, 18'h10020, 16'h7777, 2'b00);            // R9 empty mask
    doReq(1'b0, 18'h10020, 16'h0000, 2'b11);
    drain();

    // R8: intruding request while busy is ignored
    doReq(1'b1, 18'h00040, 16'h1111, 2'b11);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 18'h00077; reqWdata = 16'hBEEF; reqMask = 2'b11;
    repeat (3) begin @(posedge clk); #2; end
    check(busy, "R8 busy during access", 32'(busy), 1);
    reqValid = 1'b0;
    drain();
    doReq(1'b0, 18'h00077, 16'h0000, 2'b11);            // R8 must read unchanged word
    doReq(1'b0, 18'h00040, 16'h0000, 2'b11);
    doReq(1'b0, 18'h10020, 16'h0000, 2'b00);            // R9 empty-mask read
    drain();
    repeat (4) @(posedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule